// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external master read and write a bank of 8-bit configuration registers over a four-wire serial link: active-low select, serial clock, data in and data out. The whole slave runs on a fast system clock. The three incoming lines are brought in through two-flop synchronisers, and serial clock edges are found by comparing each synchronised sample with the one before it. The serial clock must be at least 30 times slower than the system clock. The registers are held in system clock flops, so the settings last only while that clock runs. Each register's value is also exported on a flat bus for the logic that uses it.

A frame opens with a command bit (1 for write, 0 for read), followed by a 7-bit address sent MSB first. A write frame then carries 8 data bits, MSB first. The data is committed to the addressed register only when select is released, and only if all 16 bits arrived. A read frame returns the addressed register on the data-out line, MSB first. The first bit is driven on the serial clock fall that follows the last address bit. The line is released to high impedance when select rises. Both parties change data on the falling serial clock edge and sample it on the rising edge.

The controller is a state machine with six states:
- `ST_IDLE`: not selected.
- `ST_CMD`: waiting for the command bit.
- `ST_ADDR`: shifting in the address.
- `ST_WDATA`: shifting in write data.
- `ST_WHOLD`: a full write is held until deselect.
- `ST_RDATA`: read data is being driven.

Its transitions are:
- Select fall: `ST_IDLE` to `ST_CMD`.
- Any rising serial clock edge: `ST_CMD` to `ST_ADDR`.
- Seventh address bit: `ST_ADDR` to `ST_WDATA` for a write, or `ST_ADDR` to `ST_RDATA` for a read.
- Eighth data bit: `ST_WDATA` to `ST_WHOLD`.
- Select rise: any state back to `ST_IDLE`, committing the write if the state was `ST_WHOLD`.

Top module: `cfgspi_slave`

## Requirements
- R1: After reset every register reads 0 on `cfg_regs` and `miso_en` is 0.
- R2: A write frame loads the addressed register with the data byte. The frame is command bit 1, then a 7-bit address, then 8 data bits, both MSB first. Register `a` occupies `cfg_regs[8a+7:8a]`.
- R3: The written value stays invisible on `cfg_regs` until select rises; with select still low after the 16th bit, the register keeps its old value.
- R4: A read frame (command bit 0, then a 7-bit address) returns the register's 8 bits MSB first on `miso`. The MSB is driven after the first serial clock fall that follows the last address bit, and each bit is valid at the following rising edge.
- R5: `miso_en` is 1 only from the last address bit of a read until select rises. `miso` is high impedance whenever `miso_en` is 0. `miso_en` stays 0 throughout write frames.
- R6: A write frame cut short by a select rise before its 16th bit changes no register.
- R7: During a read the serial input is ignored: whatever it carries, no register changes.
- R8: Serial clocks beyond the 16th in a write frame are ignored; the first 8 data bits are committed.
- R9: The bit counter restarts on every select fall, so a complete frame right after a truncated one decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 30x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, high impedance when not reading |
| miso_en | output | 1 | Drive enable of `miso` |
| cfg_regs | output | 1024 | All registers, register `a` at bits `8a+7:8a` |

## Verification
The main function is tried with a full sweep: every one of the 128 addresses is written with an arithmetic byte pattern and then read back. The pattern differs in each address, so a stuck address bit, a swapped bit order or a misplaced field shows up as a mismatch. Read frames carry a varying pattern on the serial input, so any leak of that input into the bank changes the final comparison of the whole register image. Write frames are truncated at 1, 8, 9 and 15 bits to separate the commit-on-complete rule from a commit on any deselect. One frame is overlong to show that extra clocks are dropped, and a frame that follows a truncated one shows that the bit counter restarts on select.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_WHOLD,
        ST_RDATA
    } fsm_state_t;

endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic stage1;
        logic stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= RST_VAL[g];
                stage2 <= RST_VAL[g];
            end else begin
                stage1 <= d[g];
                stage2 <= stage1;
            end
        end
        assign q[g] = stage2;
    end

endmodule

// File: rtl/cfgspi_edge.sv
module cfgspi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sclk_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise
);

    logic cs_prev;
    logic sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    always_comb begin
        sclk_rise = sclk_s & ~sclk_prev;
        sclk_fall = ~sclk_s & sclk_prev;
        cs_fall   = ~cs_s & cs_prev;
        cs_rise   = cs_s & ~cs_prev;
    end

endmodule

// File: rtl/cfgspi_regbank.sv
module cfgspi_regbank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [DW-1:0]             rd_data,
    output logic [(1<<AW)*DW-1:0]     regs_flat
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*DW +: DW] = regs[g];
    end

    assign rd_data = regs[rd_addr];

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/cfgspi_fsm.sv
module cfgspi_fsm
    import cfgspi_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          mosi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          miso_d,
    output logic          miso_en
);

    localparam int MAXB  = (AW > DW) ? AW : DW;
    localparam int CNT_W = $clog2(MAXB + 1);

    fsm_state_t       state;
    fsm_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             is_wr;
    logic [AW-1:0]    addr_sh;
    logic [DW-1:0]    data_sh;
    logic [DW-1:0]    rd_sh;
    logic             miso_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (cs_fall) nxt = ST_CMD;
                ST_CMD:   if (sclk_rise) nxt = ST_ADDR;
                ST_ADDR:  if (sclk_rise && cnt == CNT_W'(AW-1))
                              nxt = is_wr ? ST_WDATA : ST_RDATA;
                ST_WDATA: if (sclk_rise && cnt == CNT_W'(DW-1)) nxt = ST_WHOLD;
                ST_WHOLD: nxt = ST_WHOLD;
                ST_RDATA: nxt = ST_RDATA;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // shift path and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            is_wr   <= 1'b0;
            addr_sh <= '0;
            data_sh <= '0;
            rd_sh   <= '0;
            miso_q  <= 1'b0;
        end else if (cs_fall) begin
            cnt    <= '0;
            miso_q <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: if (sclk_rise) begin
                    is_wr <= mosi_s;
                    cnt   <= '0;
                end
                ST_ADDR: if (sclk_rise) begin
                    addr_sh <= {addr_sh[AW-2:0], mosi_s};
                    cnt     <= (cnt == CNT_W'(AW-1)) ? '0 : cnt + 1'b1;
                end
                ST_WDATA: if (sclk_rise) begin
                    data_sh <= {data_sh[DW-2:0], mosi_s};
                    cnt     <= cnt + 1'b1;
                end
                ST_RDATA: if (sclk_fall) begin
                    if (cnt == '0) begin
                        miso_q <= rd_data[DW-1];
                        rd_sh  <= {rd_data[DW-2:0], 1'b0};
                    end else begin
                        miso_q <= rd_sh[DW-1];
                        rd_sh  <= {rd_sh[DW-2:0], 1'b0};
                    end
                    if (cnt != CNT_W'(DW)) cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_WHOLD) && cs_rise;
        wr_addr = addr_sh;
        wr_data = data_sh;
        rd_addr = addr_sh;
        miso_en = (state == ST_RDATA);
        miso_d  = miso_q;
    end

    // R4
    rd_en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_en) |-> $past(sclk_rise));

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miso_en) |-> $past(cs_rise));

endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  mosi,
    output wire                   miso,
    output logic                  miso_en,
    output logic [(1<<AW)*DW-1:0] cfg_regs
);

    logic [2:0]    sync_q;
    logic          cs_s, sclk_s, mosi_s;
    logic          sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_data;
    logic          miso_d;

    cfgspi_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mosi, sclk, cs_n}),
        .q     (sync_q)
    );

    assign cs_s   = sync_q[0];
    assign sclk_s = sync_q[1];
    assign mosi_s = sync_q[2];

    cfgspi_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sclk_s    (sclk_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise)
    );

    cfgspi_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso_d    (miso_d),
        .miso_en   (miso_en)
    );

    cfgspi_regbank #(.AW(AW), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

    assign miso = miso_en ? miso_d : 1'bz;

    // R3
    wr_needs_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cs_s);

endmodule

// File: tb/sim_cfgspi_slave.sv
module sim_cfgspi_slave;

    localparam int HALF = 16;
    localparam int NREG = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    wire  miso;
    logic miso_en;
    logic [NREG*8-1:0] cfg_regs;
    logic [NREG*8-1:0] snap;
    logic [NREG*8-1:0] model;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfgspi_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .miso_en  (miso_en),
        .cfg_regs (cfg_regs)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sends n bits of bits (MSB first from bit 23); rd gets bits 8..15 of miso.
    task automatic frame(input logic [23:0] bits, input int n, input bit is_rd,
                         output logic [7:0] rd, output int en_bad);
        rd = '0;
        en_bad = 0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            mosi = bits[23-i];
            wait_clk(HALF);
            if (i >= 8 && i < 16 && is_rd) rd = {rd[6:0], miso};
            if (miso_en !== ((i >= 8) && is_rd)) en_bad++;
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(HALF);
        snap = cfg_regs;
        cs_n = 1'b1;
        wait_clk(8);
        if (miso_en !== 1'b0) en_bad++;
    endtask

    initial begin
        logic [7:0] rd;
        int eb;
        wait_clk(4);
        // R1
        check(cfg_regs == '0, "R1 regs after reset", cfg_regs[31:0], 0);
        check(miso_en == 1'b0, "R1 miso_en after reset", miso_en, 0);
        rst_n = 1'b1;
        wait_clk(4);
        model = '0;

        for (int a = 0; a < NREG; a++) begin
            frame({1'b1, 7'(a), pat(a), 8'h00}, 16, 1'b0, rd, eb);
            // R3
            check(snap[a*8 +: 8] == 8'h00, "R3 before deselect", snap[a*8 +: 8], 0);
            // R2
            check(cfg_regs[a*8 +: 8] == pat(a), "R2 write lands", cfg_regs[a*8 +: 8], pat(a));
            // R5
            check(eb == 0, "R5 no enable in write", eb, 0);
            model[a*8 +: 8] = pat(a);
        end

        for (int a = 0; a < NREG; a++) begin
            logic [7:0] junk;
            junk = 8'(a ^ 8'h5A);
            frame({1'b0, 7'(a), junk, 8'h00}, 16, 1'b1, rd, eb);
            // R4
            check(rd == pat(a), "R4 read data", rd, pat(a));
            // R5
            check(eb == 0, "R5 read enable window", eb, 0);
        end
        // R7
        check(cfg_regs == model, "R7 mosi ignored in read", cfg_regs[31:0], model[31:0]);

        // R6: truncated writes to register 10
        for (int k = 0; k < 4; k++) begin
            int nb;
            nb = (k == 0) ? 1 : (k == 1) ? 8 : (k == 2) ? 9 : 15;
            frame({1'b1, 7'd10, 8'hFF, 8'h00}, nb, 1'b0, rd, eb);
            check(cfg_regs == model, "R6 truncated write", cfg_regs[10*8 +: 8], model[10*8 +: 8]);
        end

        // R9: full write after truncation
        frame({1'b1, 7'd10, 8'hC3, 8'h00}, 16, 1'b0, rd, eb);
        model[10*8 +: 8] = 8'hC3;
        check(cfg_regs == model, "R9 frame after truncation", cfg_regs[10*8 +: 8], 8'hC3);

        // R8: overlong write
        frame({1'b1, 7'd99, 8'h3C, 8'hF0}, 20, 1'b0, rd, eb);
        model[99*8 +: 8] = 8'h3C;
        check(cfg_regs == model, "R8 extra clocks ignored", cfg_regs[99*8 +: 8], 8'h3C);

        // R4 on the rewritten register
        frame({1'b0, 7'd10, 8'hFF, 8'h00}, 16, 1'b1, rd, eb);
        check(rd == 8'hC3, "R4 read after rewrite", rd, 8'hC3);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule